// File: doc/BRIEF.md
# Super-I/O Configuration Port Controller

This block is the configuration front end of an I/O-mapped peripheral. Software reaches it through two byte-wide I/O ports. The lower port holds a register index and the port directly above it carries the register's data. A strap input picks which of two base addresses the pair answers on.

After reset the block is locked and ignores configuration traffic. Writing the entry key byte to the index port twice in a row opens it, and writing the exit key byte to the index port closes it again. While it is open, the first 48 register indices are global to the whole peripheral. They hold the logical-device select and a read-only 16-bit chip identifier. Every higher index is forwarded to the register bank of the currently selected logical device over a simple banked register bus. Each forwarded access carries the device number with it.

The per-device register files sit outside this block. They answer forwarded reads combinationally on `dev_rdata`.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is locked (`cfg_active` = 0) and the logical-device select reads 0x00 once the block is opened.
- R2: Two consecutive index-port writes of 0x87 open the block. `cfg_active` rises on the clock edge that takes the second key.
- R3: After one 0x87, an index-port write of any other value returns the entry sequence to its start, so 0x87, 0x00, 0x87 leaves the block locked. Data-port traffic does not affect the sequence.
- R4: While the block is open, an index-port write of 0xAA locks it. That write does not change the stored index.
- R5: With `strap_alt` = 0 the index port is at 0x002E and the data port at 0x002F. With `strap_alt` = 1 they are at 0x004E and 0x004F. Accesses to any other address have no effect, and reads of other addresses return 0xFF.
- R6: Index 0x20 reads 0x10 and index 0x21 reads 0x61, which is the identifier 0x1061 with the high byte first. Writes to these two indices are ignored.
- R7: Index 0x07 is the logical-device select. It is readable and writable, it holds its value between writes, and it drives `dev_num`.
- R8: Every other global index from 0x00 to 0x2F reads 0x00 and ignores writes. No access to any global index is forwarded, and global registers read the same whatever device is selected.
- R9: A data-port write to an index from 0x30 to 0xFF produces a one-cycle `dev_wr` carrying `dev_num` = selected device, `dev_idx` = index and `dev_wdata` = the byte. A data-port read at such an index drives `dev_rd` and returns `dev_rdata`.
- R10: While the block is locked, data-port reads return 0xFF, `dev_wr` and `dev_rd` stay low, and index writes other than the entry key change nothing.
- R11: Locking and reopening the block keeps the logical-device select.
- R12: While the block is open, a read of the index port returns the stored index. While it is locked, such a read returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Base-address strap: 0 selects 0x2E, 1 selects 0x4E |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write byte |
| io_rdata | output | 8 | I/O read byte, valid in the same cycle as `io_rd` |
| cfg_active | output | 1 | High while configuration mode is open |
| dev_wr | output | 1 | Banked register write strobe |
| dev_rd | output | 1 | Banked register read strobe |
| dev_num | output | 8 | Logical device number of the banked access |
| dev_idx | output | 8 | Register index of the banked access |
| dev_wdata | output | 8 | Banked write byte |
| dev_rdata | input | 8 | Banked read byte from the selected device |

## Verification
Some properties are checked by assertions on every cycle:
- the block opens only on the clock edge after a second consecutive entry key;
- a broken sequence drops back to locked, and the exit key always locks;
- the device select holds between its own writes;
- while locked, data-port reads give 0xFF and no banked strobe appears;
- global indices are never forwarded, and the identifier high byte is returned at its index.

Other behaviour only the bench scenarios can show:
- the exact byte values at every global index;
- the pairing of device number, index and data on forwarded writes across several device selections;
- the effect of the base-address strap;
- that the device select survives a lock and reopen.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  // True when an index addresses the global (unbanked) register range.
  function automatic logic idx_is_global(input logic [7:0] idx, input logic [7:0] limit);
    return idx < limit;
  endfunction

  // Select one byte of the chip identifier.
  function automatic logic [7:0] id_byte(input logic [15:0] id, input logic low_half);
    return low_half ? id[7:0] : id[15:8];
  endfunction

  // Port address for a given base and port offset (0 = index, 1 = data).
  function automatic logic [15:0] port_addr(input logic [15:0] base, input int unsigned offs);
    return base + 16'(offs);
  endfunction

endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] BASE_PRI = 16'h002E,
  parameter logic [15:0] BASE_ALT = 16'h004E
) (
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              dat_wr,
  output logic              dat_rd
);
  import sio_cfg_pkg::*;

  localparam int NPORT = 2;

  logic [15:0]      base_sel;
  logic [NPORT-1:0] port_hit;

  assign base_sel = strap_alt ? BASE_ALT : BASE_PRI;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign port_hit[g] = (io_addr == ADDR_W'(port_addr(base_sel, g)));
  end

  assign idx_wr = io_wr & port_hit[0];
  assign idx_rd = io_rd & port_hit[0];
  assign dat_wr = io_wr & port_hit[1];
  assign dat_rd = io_rd & port_hit[1];

endmodule

// File: rtl/sio_key_seq.sv
module sio_key_seq #(
  parameter logic [7:0] KEY_ENTER = 8'h87,
  parameter logic [7:0] KEY_EXIT  = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open,
  output logic       idx_load
);
  import sio_cfg_pkg::*;

  key_state_e state_q, state_d;

  // Named events for the checks below.
  logic ev_enter_byte;
  logic ev_exit_byte;
  logic ev_break;

  assign ev_enter_byte = idx_wr && (wdata == KEY_ENTER);
  assign ev_exit_byte  = idx_wr && (wdata == KEY_EXIT);
  assign ev_break      = idx_wr && (wdata != KEY_ENTER);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      KS_LOCKED: if (ev_enter_byte) state_d = KS_HALF;
      KS_HALF:   if (ev_enter_byte) state_d = KS_OPEN;
                 else if (ev_break) state_d = KS_LOCKED;
      KS_OPEN:   if (ev_exit_byte)  state_d = KS_LOCKED;
      default:   state_d = KS_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_d;
  end

  assign open     = (state_q == KS_OPEN);
  assign idx_load = open && idx_wr && !ev_exit_byte;

  AST_ENTRY_TWO_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(ev_enter_byte && state_q == KS_HALF)); // R2

  AST_BROKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_HALF && ev_break) |=> (state_q == KS_LOCKED)); // R3

  AST_EXIT_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (open && ev_exit_byte) |=> !open); // R4

endmodule

// File: rtl/sio_global_regs.sv
module sio_global_regs #(
  parameter logic [15:0] CHIP_ID   = 16'h1061,
  parameter logic [7:0]  LDN_IDX   = 8'h07,
  parameter logic [7:0]  ID_HI_IDX = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       open,
  input  logic       idx_load,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  output logic [7:0] index_q,
  output logic [7:0] ldn_q,
  output logic [7:0] glob_rdata
);
  import sio_cfg_pkg::*;

  localparam logic [7:0] ID_LO_IDX = ID_HI_IDX + 8'd1;

  logic ldn_we;
  assign ldn_we = open && dat_wr && (index_q == LDN_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= '0;
      ldn_q   <= '0;
    end else begin
      if (idx_load) index_q <= wdata;
      if (ldn_we)   ldn_q   <= wdata;
    end
  end

  always_comb begin
    if (index_q == LDN_IDX)        glob_rdata = ldn_q;
    else if (index_q == ID_HI_IDX) glob_rdata = id_byte(CHIP_ID, 1'b0);
    else if (index_q == ID_LO_IDX) glob_rdata = id_byte(CHIP_ID, 1'b1);
    else                           glob_rdata = 8'h00;
  end

  AST_LDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ldn_we |=> $stable(ldn_q)); // R7

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] BASE_PRI   = 16'h002E,
  parameter logic [15:0] BASE_ALT   = 16'h004E,
  parameter logic [7:0]  KEY_ENTER  = 8'h87,
  parameter logic [7:0]  KEY_EXIT   = 8'hAA,
  parameter logic [15:0] CHIP_ID    = 16'h1061,
  parameter logic [7:0]  LDN_IDX    = 8'h07,
  parameter logic [7:0]  ID_HI_IDX  = 8'h20,
  parameter logic [7:0]  BANK_START = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              cfg_active,
  output logic              dev_wr,
  output logic              dev_rd,
  output logic [7:0]        dev_num,
  output logic [7:0]        dev_idx,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        dev_rdata
);
  import sio_cfg_pkg::*;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  logic       idx_wr, idx_rd, dat_wr, dat_rd;
  logic       open, idx_load;
  logic [7:0] index_q, ldn_q, glob_rdata;
  logic       sel_global;

  sio_port_decode #(
    .ADDR_W(ADDR_W), .BASE_PRI(BASE_PRI), .BASE_ALT(BASE_ALT)
  ) u_dec (
    .strap_alt(strap_alt), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .idx_wr(idx_wr), .idx_rd(idx_rd), .dat_wr(dat_wr), .dat_rd(dat_rd)
  );

  sio_key_seq #(
    .KEY_ENTER(KEY_ENTER), .KEY_EXIT(KEY_EXIT)
  ) u_key (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(io_wdata),
    .open(open), .idx_load(idx_load)
  );

  sio_global_regs #(
    .CHIP_ID(CHIP_ID), .LDN_IDX(LDN_IDX), .ID_HI_IDX(ID_HI_IDX)
  ) u_glob (
    .clk(clk), .rst_n(rst_n), .open(open), .idx_load(idx_load),
    .dat_wr(dat_wr), .wdata(io_wdata), .index_q(index_q), .ldn_q(ldn_q),
    .glob_rdata(glob_rdata)
  );

  assign sel_global = idx_is_global(index_q, BANK_START);

  assign cfg_active = open;
  assign dev_wr     = open && dat_wr && !sel_global;
  assign dev_rd     = open && dat_rd && !sel_global;
  assign dev_num    = ldn_q;
  assign dev_idx    = index_q;
  assign dev_wdata  = io_wdata;

  always_comb begin
    io_rdata = IDLE_BYTE;
    if (open) begin
      if (idx_rd)      io_rdata = index_q;
      else if (dat_rd) io_rdata = sel_global ? glob_rdata : dev_rdata;
    end
  end

  AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !cfg_active) |-> (io_rdata == 8'hFF)); // R10

  AST_NO_DEV_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_active |-> !(dev_wr || dev_rd)); // R10

  AST_GLOBAL_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && index_q < BANK_START) |-> !dev_wr); // R8

  AST_ID_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_active && dat_rd && index_q == ID_HI_IDX) |-> (io_rdata == CHIP_ID[15:8])); // R6

endmodule

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_alt = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        cfg_active, dev_wr, dev_rd;
  logic [7:0]  dev_num, dev_idx, dev_wdata, dev_rdata;

  int n_chk = 0, n_fail = 0;
  int dev_wr_cnt = 0, dev_rd_cnt = 0;
  logic [7:0] cap_num, cap_idx, cap_dat;
  bit done = 0;

  always #10 clk = ~clk;

  sio_cfg_port u0 (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cfg_active(cfg_active), .dev_wr(dev_wr), .dev_rd(dev_rd),
    .dev_num(dev_num), .dev_idx(dev_idx), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata)
  );

  function automatic logic [7:0] bank_model(input logic [7:0] n, input logic [7:0] i);
    return i ^ (n * 8'h1D) ^ 8'h3C;
  endfunction

  assign dev_rdata = bank_model(dev_num, dev_idx);

  always @(posedge clk) begin
    if (dev_wr) begin
      dev_wr_cnt <= dev_wr_cnt + 1;
      cap_num <= dev_num; cap_idx <= dev_idx; cap_dat <= dev_wdata;
    end
    if (dev_rd) dev_rd_cnt <= dev_rd_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #2 d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  function automatic logic [15:0] base();
    return strap_alt ? 16'h004E : 16'h002E;
  endfunction

  task automatic unlock();
    wr(base(), 8'h87); wr(base(), 8'h87);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    int w0;
    do_reset();

    // R1 / R10: locked after reset
    chk("R1 locked after reset", cfg_active, 0);
    rd(16'h002F, r); chk("R10 locked data read", r, 8'hFF);
    rd(16'h002E, r); chk("R12 locked index read", r, 8'hFF);
    wr(16'h002E, 8'h07); wr(16'h002F, 8'h05);
    chk("R10 non-key write keeps lock", cfg_active, 0);
    chk("R10 no strobes while locked", dev_wr_cnt + dev_rd_cnt, 0);

    // R5: wrong base ignored
    wr(16'h004E, 8'h87); wr(16'h004E, 8'h87);
    chk("R5 other base ignored", cfg_active, 0);
    rd(16'h004F, r); chk("R5 other address reads FF", r, 8'hFF);

    // R3: broken sequence, data traffic neutral
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h00); wr(16'h002E, 8'h87);
    chk("R3 broken sequence stays locked", cfg_active, 0);
    wr(16'h002F, 8'h11);
    chk("R3 half state still locked", cfg_active, 0);
    wr(16'h002E, 8'h87);
    chk("R2 second key opens", cfg_active, 1);

    // R1 / R7: device select reset value
    wr(16'h002E, 8'h07); rd(16'h002F, r); chk("R1 LDN reset value", r, 8'h00);

    // R6: identifier and write immunity
    wr(16'h002E, 8'h20); wr(16'h002F, 8'hEE); rd(16'h002F, r); chk("R6 id high", r, 8'h10);
    wr(16'h002E, 8'h21); wr(16'h002F, 8'hEE); rd(16'h002F, r); chk("R6 id low", r, 8'h61);

    // R8 / R12: sweep remaining global indices
    w0 = dev_wr_cnt;
    for (int i = 0; i < 48; i++) begin
      if (i == 7 || i == 32 || i == 33) continue;
      wr(16'h002E, 8'(i));
      rd(16'h002E, r); chk("R12 index readback", r, 8'(i));
      wr(16'h002F, 8'h5A);
      rd(16'h002F, r); chk("R8 global reads zero", r, 8'h00);
    end
    chk("R8 no forwarding of globals", dev_wr_cnt - w0, 0);

    // R7 / R9: device selects and banked accesses
    for (int n = 0; n < 4; n++) begin
      wr(16'h002E, 8'h07); wr(16'h002F, 8'(n));
      rd(16'h002F, r); chk("R7 LDN readback", r, 8'(n));
      wr(16'h002E, 8'h20); rd(16'h002F, r); chk("R8 global same across LDN", r, 8'h10);
      for (int k = 0; k < 4; k++) begin
        logic [7:0] ix, dv;
        ix = (k == 0) ? 8'h30 : (k == 1) ? 8'h87 : (k == 2) ? 8'hF0 : 8'hFF;
        dv = 8'(n * 16 + k + 8'hA0);
        w0 = dev_wr_cnt;
        wr(16'h002E, ix); wr(16'h002F, dv);
        chk("R9 one write strobe", dev_wr_cnt - w0, 1);
        chk("R9 write tag", {cap_num, cap_idx, cap_dat}, {8'(n), ix, dv});
        rd(16'h002F, r); chk("R9 banked read", r, bank_model(8'(n), ix));
      end
    end

    // R4 / R10: exit key, index unchanged
    wr(16'h002E, 8'h45);
    wr(16'h002E, 8'hAA);
    chk("R4 exit key locks", cfg_active, 0);
    w0 = dev_wr_cnt;
    wr(16'h002F, 8'h99); rd(16'h002F, r);
    chk("R10 locked data read after exit", r, 8'hFF);
    chk("R10 no strobe after exit", dev_wr_cnt - w0, 0);
    unlock();
    rd(16'h002E, r); chk("R4 exit byte not stored as index", r, 8'h45);

    // R11: select retained across lock
    wr(16'h002E, 8'h07); rd(16'h002F, r); chk("R11 LDN kept after relock", r, 8'h03);

    // R5: alternate strap
    strap_alt = 1'b1; do_reset();
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h87);
    chk("R5 primary base ignored with strap", cfg_active, 0);
    unlock();
    chk("R5 alternate base opens", cfg_active, 1);
    wr(16'h004E, 8'h21); rd(16'h004F, r); chk("R5 id via alternate base", r, 8'h61);
    wr(16'h002E, 8'hAA);
    chk("R5 exit at wrong base ignored", cfg_active, 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule